// File: doc/BRIEF.md
# Serial EEPROM Write-Cycle Controller

This block is the slave-side control for the write path of a two-wire serial EEPROM. A bit-level bus front end, which is not part of this block, turns SCL/SDA activity into single-cycle events: start, stop, and byte received. Each byte event comes with the byte value and an address-match flag. From these events the controller follows a write frame: a device byte, then a word address byte, then one data byte. It decides whether the frame may be committed to the array. If so, it runs a timed internal write cycle and holds the device silent until that cycle ends.

The write-protect level is captured on the byte event of the data byte. That event corresponds to the SCL edge that clocks in D0. The captured level is used from that point on, so later changes on the pin have no effect on the pending write. The internal cycle starts only on the stop condition. It lasts a parameterised number of millisecond-scale timer ticks. The product of tick period and tick count is checked at elaboration against a 10 ms ceiling. While the cycle runs, every bus event is dropped and the acknowledge enable stays low. A host finds out that the cycle has ended by polling: it sends the device address until an acknowledge comes back. The committed byte appears in the behavioural array at the end of the cycle.

Top module: `eeprom_wcycle_ctrl`

## Requirements
- R1: After reset, `busy` and `mem_we` are low and every array location reads zero.
- R2: A frame made of start, a matched device byte with bit 0 = 0 (write), a word byte, a data byte, and stop, with write-protect captured low, raises `busy` in the cycle after the stop event. The low ADDR_W bits of the word byte select the location.
- R3: `busy` stays high through exactly WR_TICKS pulses of `tick`. The location keeps its old value until the edge of the last tick pulse. At that edge the new value appears and `busy` falls.
- R4: `ack_en` equals `addr_match` while `busy` is low and is forced low while `busy` is high.
- R5: Every bus event that arrives while `busy` is high is ignored. A complete frame sent in that window changes no location and does not lengthen the cycle.
- R6: Write-protect is sampled on the data byte event, and only that sample counts. A captured high blocks the cycle and leaves the array unchanged, even if the pin is low at the stop. A captured low allows the write, even if the pin is high at the stop.
- R7: A stop that arrives before a data byte has been received starts no cycle.
- R8: A device byte that is unmatched, or that has bit 0 = 1 (read), leads to no cycle at the following stop.
- R9: A repeated start before the stop discards the pending data byte, so the next stop starts no cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_start | input | 1 | Start condition event |
| bus_stop | input | 1 | Stop condition event |
| bus_byte_vld | input | 1 | Byte received event (on the D0 edge) |
| bus_byte | input | 8 | Received byte value |
| addr_match | input | 1 | Device address matches this slave |
| wp | input | 1 | Write-protect pin level |
| tick | input | 1 | Timer tick pulse, one per millisecond-scale period |
| rd_addr | input | ADDR_W | Array read address |
| rd_data | output | 8 | Array read data |
| ack_en | output | 1 | Acknowledge enable to the bit-level front end |
| busy | output | 1 | Internal write cycle in progress |
| mem_we | output | 1 | Array write strobe |
| mem_addr | output | ADDR_W | Array write address |
| mem_wdata | output | 8 | Array write data |

## Verification
The assertions assume that each event input is a single-cycle pulse and that at most one of start, stop and byte is raised in any cycle. The stimulus drives every event for exactly one clock, on a falling edge, and never overlaps two of them. The assertions also assume that `tick` is a pulse whose period is far longer than one frame. The bench relies on this by giving ticks only when it chooses to and by sending whole frames between ticks. The sweep covers every word address of the small default array. Expected array contents are kept in a bench-side model that is updated only when the requirements say a commit happens.

// File: rtl/eewc_pkg.sv
package eewc_pkg;

    localparam int unsigned WR_LIMIT_US = 10000;

    typedef enum logic [2:0] {
        FS_IDLE,
        FS_DEVICE,
        FS_WORD,
        FS_DATA,
        FS_SKIP
    } frame_st_e;

    typedef struct packed {
        logic [7:0] data;
        logic       prot;
    } wr_req_t;

    function automatic logic is_write_sel(input logic [7:0] dev_byte);
        return ~dev_byte[0];
    endfunction

endpackage

// File: rtl/eewc_frame.sv
module eewc_frame
    import eewc_pkg::*;
#(
    parameter int unsigned ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              busy,
    input  logic              ev_start,
    input  logic              ev_stop,
    input  logic              ev_byte,
    input  logic [7:0]        byte_in,
    input  logic              addr_match,
    input  logic              wp,
    output logic              go,
    output logic [ADDR_W-1:0] word_addr,
    output wr_req_t           req
);

    frame_st_e st;
    logic      pend;
    logic      s_ok, p_ok, b_ok;

    // all traffic is dropped while the internal cycle runs
    assign s_ok = ev_start & ~busy;
    assign p_ok = ev_stop  & ~busy;
    assign b_ok = ev_byte  & ~busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= FS_IDLE;
            pend      <= 1'b0;
            word_addr <= '0;
            req       <= '0;
        end else if (s_ok) begin
            st   <= FS_DEVICE;
            pend <= 1'b0;
        end else if (p_ok) begin
            st   <= FS_IDLE;
            pend <= 1'b0;
        end else if (b_ok) begin
            case (st)
                FS_DEVICE: st <= (addr_match && is_write_sel(byte_in)) ? FS_WORD : FS_SKIP;
                FS_WORD: begin
                    word_addr <= byte_in[ADDR_W-1:0];
                    st        <= FS_DATA;
                end
                FS_DATA: begin
                    req.data <= byte_in;
                    req.prot <= wp;
                    pend     <= 1'b1;
                end
                default: st <= st;
            endcase
        end
    end

    assign go = p_ok & pend & ~req.prot;

    AST_FRAME_FROZEN: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(st)); // R5

endmodule

// File: rtl/eewc_timer.sv
module eewc_timer #(
    parameter int unsigned WR_TICKS = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic go,
    input  logic tick,
    output logic busy,
    output logic done
);

    localparam int unsigned CNT_W = $clog2(WR_TICKS + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WR_TICKS - 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (!busy) begin
            if (go) begin
                busy <= 1'b1;
                cnt  <= '0;
            end
        end else if (tick) begin
            if (cnt == LAST) begin
                busy <= 1'b0;
                cnt  <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    assign done = busy & tick & (cnt == LAST);

    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (rst)
        (busy && !tick) |=> busy); // R3

endmodule

// File: rtl/eewc_array.sv
module eewc_array #(
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] wa,
    input  logic [DATA_W-1:0] wd,
    input  logic [ADDR_W-1:0] ra,
    output logic [DATA_W-1:0] rd
);

    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[wa] <= wd;
        end
    end

    assign rd = mem[ra];

endmodule

// File: rtl/eeprom_wcycle_ctrl.sv
module eeprom_wcycle_ctrl
    import eewc_pkg::*;
#(
    parameter int unsigned ADDR_W   = 4,
    parameter int unsigned WR_TICKS = 5,
    parameter int unsigned TICK_US  = 1000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_start,
    input  logic              bus_stop,
    input  logic              bus_byte_vld,
    input  logic [7:0]        bus_byte,
    input  logic              addr_match,
    input  logic              wp,
    input  logic              tick,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    output logic              ack_en,
    output logic              busy,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata
);

    generate
        if (WR_TICKS < 1 || WR_TICKS * TICK_US > WR_LIMIT_US || ADDR_W > 8) begin : g_bad_cfg
            $error("write cycle exceeds 10 ms or bad address width");
        end
    endgenerate

    logic              go;
    logic              done;
    logic [ADDR_W-1:0] word_addr;
    wr_req_t           req;

    eewc_frame #(.ADDR_W(ADDR_W)) u_frame (
        .clk        (clk),
        .rst        (rst),
        .busy       (busy),
        .ev_start   (bus_start),
        .ev_stop    (bus_stop),
        .ev_byte    (bus_byte_vld),
        .byte_in    (bus_byte),
        .addr_match (addr_match),
        .wp         (wp),
        .go         (go),
        .word_addr  (word_addr),
        .req        (req)
    );

    eewc_timer #(.WR_TICKS(WR_TICKS)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .go   (go),
        .tick (tick),
        .busy (busy),
        .done (done)
    );

    // hold the committed request for the whole window
    always_ff @(posedge clk) begin
        if (rst) begin
            mem_addr  <= '0;
            mem_wdata <= '0;
        end else if (go && !busy) begin
            mem_addr  <= word_addr;
            mem_wdata <= req.data;
        end
    end

    assign mem_we = done;
    assign ack_en = addr_match & ~busy;

    eewc_array #(.ADDR_W(ADDR_W), .DATA_W(8)) u_array (
        .clk (clk),
        .rst (rst),
        .we  (mem_we),
        .wa  (mem_addr),
        .wd  (mem_wdata),
        .ra  (rd_addr),
        .rd  (rd_data)
    );

    AST_RISE_ON_STOP: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(bus_stop)); // R2

    AST_WE_ENDS_CYCLE: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> !busy); // R3

    AST_ADDR_FIXED: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> ($stable(mem_addr) && $stable(mem_wdata))); // R5

endmodule

// File: tb/eeprom_wcycle_ctrl_bench.sv
module eeprom_wcycle_ctrl_bench;

    localparam int unsigned ADDR_W   = 4;
    localparam int unsigned WR_TICKS = 5;
    localparam int unsigned DEPTH    = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              bus_start = 1'b0, bus_stop = 1'b0, bus_byte_vld = 1'b0;
    logic [7:0]        bus_byte = '0;
    logic              addr_match = 1'b0, wp = 1'b0, tick = 1'b0;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic [7:0]        rd_data;
    logic              ack_en, busy, mem_we;
    logic [ADDR_W-1:0] mem_addr;
    logic [7:0]        mem_wdata;

    int total = 0;
    int bad   = 0;
    logic [7:0] model [DEPTH];

    always #2.5 clk = ~clk;

    eeprom_wcycle_ctrl #(.ADDR_W(ADDR_W), .WR_TICKS(WR_TICKS), .TICK_US(1000)) u_eeprom_wcycle_ctrl (
        .clk(clk), .rst(rst), .bus_start(bus_start), .bus_stop(bus_stop),
        .bus_byte_vld(bus_byte_vld), .bus_byte(bus_byte), .addr_match(addr_match),
        .wp(wp), .tick(tick), .rd_addr(rd_addr), .rd_data(rd_data), .ack_en(ack_en),
        .busy(busy), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic ev(input logic s, input logic p, input logic b, input logic [7:0] v, input logic m);
        @(negedge clk);
        bus_start = s; bus_stop = p; bus_byte_vld = b; bus_byte = v; addr_match = m;
        @(negedge clk);
        bus_start = 0; bus_stop = 0; bus_byte_vld = 0; addr_match = 0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
        end
    endtask

    task automatic frame(input logic [7:0] dev, input logic m, input logic [7:0] word,
                         input logic [7:0] data, input logic wp_d, input logic wp_s);
        ev(1, 0, 0, 8'h00, 0);
        ev(0, 0, 1, dev, m);
        ev(0, 0, 1, word, 0);
        wp = wp_d;
        ev(0, 0, 1, data, 0);
        wp = wp_s;
        ev(0, 1, 0, 8'h00, 0);
        wp = 1'b0;
    endtask

    task automatic peek(input int a, output logic [7:0] v);
        rd_addr = ADDR_W'(a);
        #1;
        v = rd_data;
    endtask

    task automatic check_all(input string tag);
        logic [7:0] v;
        for (int a = 0; a < DEPTH; a++) begin
            peek(a, v);
            chk(tag, v, model[a]);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] v;
        for (int a = 0; a < DEPTH; a++) model[a] = 8'h00;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk); #1;
        // R1 reset state
        chk("R1 busy", busy, 0);
        chk("R1 we", mem_we, 0);
        check_all("R1 array");
        addr_match = 1'b1; #1;
        chk("R4 ack idle", ack_en, 1);
        addr_match = 1'b0;

        // sweep every location
        for (int a = 0; a < DEPTH; a++) begin
            logic [7:0] d;
            d = 8'((a * 37 + 5) & 255);
            frame(8'hA0, 1, {4'hC, 4'(a)}, d, 0, 0);
            #1;
            chk("R2 busy after stop", busy, 1);
            addr_match = 1'b1; #1;
            chk("R4 ack muted", ack_en, 0);
            addr_match = 1'b0;
            ticks(WR_TICKS - 1);
            peek(a, v);
            chk("R3 busy before last tick", busy, 1);
            chk("R3 old value", v, model[a]);
            ticks(1);
            model[a] = d;
            peek(a, v);
            chk("R3 busy after last tick", busy, 0);
            chk("R2 data written", v, d);
            addr_match = 1'b1; #1;
            chk("R4 ack after cycle", ack_en, 1);
            addr_match = 1'b0;
        end
        check_all("R2 sweep");

        // R5 traffic during busy
        frame(8'hA0, 1, 8'h03, 8'h5A, 0, 0);
        frame(8'hA0, 1, 8'h07, 8'hEE, 0, 0);
        ticks(WR_TICKS - 1);
        chk("R5 not lengthened pre", busy, 1);
        ticks(1);
        #1;
        chk("R5 not lengthened", busy, 0);
        model[3] = 8'h5A;
        check_all("R5 array");

        // R6 protect high at D0, low at stop
        frame(8'hA0, 1, 8'h04, 8'h11, 1, 0);
        #1;
        chk("R6 blocked busy", busy, 0);
        ticks(WR_TICKS);
        check_all("R6 blocked array");
        // R6 protect low at D0, high at stop
        frame(8'hA0, 1, 8'h05, 8'h22, 0, 1);
        #1;
        chk("R6 latched low busy", busy, 1);
        ticks(WR_TICKS);
        model[5] = 8'h22;
        check_all("R6 latched array");

        // R7 stop before data byte
        ev(1, 0, 0, 8'h00, 0);
        ev(0, 0, 1, 8'hA0, 1);
        ev(0, 0, 1, 8'h06, 0);
        ev(0, 1, 0, 8'h00, 0);
        #1;
        chk("R7 no cycle", busy, 0);

        // R8 read select and unmatched device
        frame(8'hA1, 1, 8'h06, 8'h33, 0, 0);
        #1;
        chk("R8 read no cycle", busy, 0);
        frame(8'hA0, 0, 8'h06, 8'h33, 0, 0);
        #1;
        chk("R8 unmatched no cycle", busy, 0);
        ticks(WR_TICKS);
        check_all("R8 array");

        // R9 repeated start drops pending byte
        ev(1, 0, 0, 8'h00, 0);
        ev(0, 0, 1, 8'hA0, 1);
        ev(0, 0, 1, 8'h08, 0);
        ev(0, 0, 1, 8'h44, 0);
        ev(1, 0, 0, 8'h00, 0);
        ev(0, 1, 0, 8'h00, 0);
        #1;
        chk("R9 no cycle", busy, 0);
        ticks(WR_TICKS);
        check_all("R9 array");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule